// File: doc/BRIEF.md
# Slowdown-Weighted Memory Priority Rotator

This block chooses, for each short epoch, the single core whose memory requests the memory controller serves ahead of all others. Time is cut into intervals of `EPOCHS` epochs, and each epoch lasts `EPOCH_LEN` clock cycles. During an interval, every core holds top priority for a number of epochs that tracks its estimated slowdown. A core that suffers more from interference gets more protected time. Holding top priority makes a core's memory behaviour close to what it would see running by itself.

Slowdown estimates arrive as unsigned `SD_W`-bit values, one per core. Only their ratios matter. The estimates may already reflect a cache partitioning decision made upstream. The block captures the estimates at an interval boundary. A sequential divider then turns them into per-core epoch counts, and those counts govern the interval that follows. Inside an interval, the granted epochs are spread out by a smooth weighted credit rotation instead of being handed out as contiguous runs. The one-hot vector goes to the request scheduler. The binary index goes to the slowdown estimator, so that it knows which core is currently measured under top priority.

Top module: `sdprio_arbiter`

## Requirements
- R1: While `rst` is high, `prio_vec` and `interval_tick` are 0. The first interval after reset gives each core `EPOCHS/N_CORES` epochs, with any remainder going one each to the lowest-numbered cores.
- R2: From the first clock edge after reset onward, exactly one bit of `prio_vec` is set in every cycle, and `prio_id` equals the index of that bit.
- R3: Priority changes only every `EPOCH_LEN` cycles. An interval is exactly `EPOCHS` epochs long. `interval_tick` is high for the single first cycle of each interval.
- R4: With clamped slowdowns S_i (see R6) and total T, core i receives 1 + floor((EPOCHS − N_CORES)·S_i / T) epochs, plus one more if R5 selects it. Every core therefore gets at least one epoch, and the shares add up to exactly `EPOCHS`.
- R5: The epochs left over after the floor in R4 go one each to the cores with the largest S_i. Among equal S_i, the lower core index wins.
- R6: A slowdown input of 0 is treated as 1.
- R7: The value of `sd_in` present at the clock edge that starts interval k determines the shares of interval k+1. Values held at any other time have no effect. Core i uses bits [i·SD_W +: SD_W].
- R8: Within an interval, each epoch goes to the core with the largest running credit (ties go to the lower index). Each core's credit grows by its share every epoch, and the winner's credit drops by `EPOCHS`. With equal shares, priority therefore rotates through cores 0, 1, 2, … in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sd_in | input | N_CORES*SD_W | Per-core slowdown estimates, core 0 in the low bits |
| prio_vec | output | N_CORES | One-hot top-priority core for the request scheduler |
| prio_id | output | max(1,clog2(N_CORES)) | Index of the top-priority core, for the slowdown estimator |
| interval_tick | output | 1 | Pulse in the first cycle of each interval |

## Verification
The hardest case to reach is a set of leftover epochs shared among cores whose slowdowns tie. It can only be seen as epoch counts at the ports, and only two intervals after the estimates are applied. The stimulus drives a pattern in which three cores tie below a fourth, so that two leftovers split between the largest core and the lowest-indexed tied core. The one-interval capture delay is exercised by first driving a decoy value in each interval and then replacing it before the boundary. Only the final value may show up in the counts.

// File: rtl/sdprio_pkg.sv
package sdprio_pkg;

  typedef enum logic [1:0] {
    CALC_IDLE,
    CALC_LOAD,
    CALC_DIV,
    CALC_FIN
  } calc_state_e;

  // epochs given to core idx when all slowdowns are equal
  function automatic int unsigned equal_share(int unsigned total,
                                              int unsigned n,
                                              int unsigned idx);
    return total / n + ((idx < total % n) ? 1 : 0);
  endfunction

endpackage

// File: rtl/sdprio_epoch_timer.sv
module sdprio_epoch_timer #(
  parameter int EPOCHS    = 64,
  parameter int EPOCH_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  output logic epoch_end,
  output logic interval_end
);
  localparam int CCW = (EPOCH_LEN > 1) ? $clog2(EPOCH_LEN) : 1;
  localparam int ECW = (EPOCHS > 1) ? $clog2(EPOCHS) : 1;

  logic [CCW-1:0] cyc_q;
  logic [ECW-1:0] ep_q;

  assign epoch_end    = (cyc_q == CCW'(EPOCH_LEN - 1));
  assign interval_end = epoch_end && (ep_q == ECW'(EPOCHS - 1));

  // counters start at their last value so the first edge opens an interval
  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q <= CCW'(EPOCH_LEN - 1);
      ep_q  <= ECW'(EPOCHS - 1);
    end else if (epoch_end) begin
      cyc_q <= '0;
      ep_q  <= interval_end ? '0 : ep_q + 1'b1;
    end else begin
      cyc_q <= cyc_q + 1'b1;
    end
  end
endmodule

// File: rtl/sdprio_share_calc.sv
module sdprio_share_calc
  import sdprio_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int SD_W    = 8,
  parameter int EPOCHS  = 64,
  localparam int SW     = $clog2(EPOCHS + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic [N_CORES*SD_W-1:0]     sd_in,
  output logic [N_CORES-1:0][SW-1:0]  next_share,
  output logic                        idle
);
  localparam int IDW   = (N_CORES > 1) ? $clog2(N_CORES) : 1;
  localparam int SUM_W = SD_W + $clog2(N_CORES + 1);
  localparam int NUM_W = SD_W + SW;
  localparam int DCW   = $clog2(NUM_W + 1);
  localparam int RKW   = $clog2(N_CORES + 1);
  localparam int QSW   = SW + RKW;
  localparam int SPARE = EPOCHS - N_CORES;

  calc_state_e                   state_q;
  logic [N_CORES-1:0][SD_W-1:0]  sd_clamp;
  logic [N_CORES-1:0][SD_W-1:0]  sd_s;
  logic [SUM_W-1:0]              sum_in, sum_s;
  logic [IDW-1:0]                core_k;
  logic [DCW-1:0]                step_q;
  logic [SUM_W-1:0]              rem_q;
  logic [NUM_W-1:0]              quo_q;
  logic [N_CORES-1:0][SW-1:0]    q_tmp;
  logic [SUM_W:0]                rem_sh;
  logic                          take;
  logic [RKW-1:0]                rank [N_CORES];
  logic [QSW-1:0]                qsum;
  logic [SW-1:0]                 left;
  logic [N_CORES-1:0][SW-1:0]    final_share;

  // zero estimates count as one
  for (genvar i = 0; i < N_CORES; i++) begin : g_clamp
    assign sd_clamp[i] = (sd_in[i*SD_W +: SD_W] == '0) ? SD_W'(1) : sd_in[i*SD_W +: SD_W];
  end

  always_comb begin
    sum_in = '0;
    for (int i = 0; i < N_CORES; i++) sum_in = sum_in + SUM_W'(sd_clamp[i]);
  end

  // one restoring division step
  assign rem_sh = {rem_q, quo_q[NUM_W-1]};
  assign take   = (rem_sh >= {1'b0, sum_s});

  // leftover epochs ranked by slowdown, lower index first on ties
  always_comb begin
    qsum = '0;
    for (int i = 0; i < N_CORES; i++) qsum = qsum + QSW'(q_tmp[i]);
    left = SW'(QSW'(SPARE) - qsum);
    for (int i = 0; i < N_CORES; i++) begin
      rank[i] = '0;
      for (int j = 0; j < N_CORES; j++) begin
        if (j != i && ((sd_s[j] > sd_s[i]) || (sd_s[j] == sd_s[i] && j < i)))
          rank[i] = rank[i] + 1'b1;
      end
      final_share[i] = SW'(1) + q_tmp[i] + SW'(SW'(rank[i]) < left);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CALC_IDLE;
      core_k  <= '0;
      step_q  <= '0;
      rem_q   <= '0;
      quo_q   <= '0;
      sum_s   <= SUM_W'(N_CORES);
      for (int i = 0; i < N_CORES; i++) begin
        sd_s[i]       <= SD_W'(1);
        q_tmp[i]      <= '0;
        next_share[i] <= SW'(equal_share(EPOCHS, N_CORES, i));
      end
    end else if (start) begin
      sd_s    <= sd_clamp;
      sum_s   <= sum_in;
      core_k  <= '0;
      state_q <= CALC_LOAD;
    end else begin
      case (state_q)
        CALC_LOAD: begin
          quo_q   <= NUM_W'(SPARE) * NUM_W'(sd_s[core_k]);
          rem_q   <= '0;
          step_q  <= '0;
          state_q <= CALC_DIV;
        end
        CALC_DIV: begin
          rem_q  <= take ? SUM_W'(rem_sh - {1'b0, sum_s}) : SUM_W'(rem_sh);
          quo_q  <= {quo_q[NUM_W-2:0], take};
          step_q <= step_q + 1'b1;
          if (step_q == DCW'(NUM_W - 1)) begin
            q_tmp[core_k] <= SW'({quo_q[NUM_W-2:0], take});
            if (core_k == IDW'(N_CORES - 1)) begin
              state_q <= CALC_FIN;
            end else begin
              core_k  <= core_k + 1'b1;
              state_q <= CALC_LOAD;
            end
          end
        end
        CALC_FIN: begin
          next_share <= final_share;
          state_q    <= CALC_IDLE;
        end
        default: state_q <= CALC_IDLE;
      endcase
    end
  end

  assign idle = (state_q == CALC_IDLE);
endmodule

// File: rtl/sdprio_credit_pick.sv
module sdprio_credit_pick #(
  parameter int N_CORES = 4,
  parameter int EPOCHS  = 64,
  localparam int SW     = $clog2(EPOCHS + 1),
  localparam int CW     = SW + 2,
  localparam int IDW    = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic                        fresh,
  input  logic [N_CORES-1:0][CW-1:0]  cur,
  input  logic [N_CORES-1:0][SW-1:0]  weight,
  output logic [IDW-1:0]              win_idx,
  output logic [N_CORES-1:0][CW-1:0]  cur_next
);
  logic signed [CW-1:0] acc [N_CORES];
  logic signed [CW-1:0] best_val;
  logic [CW-1:0]        base;

  always_comb begin
    for (int i = 0; i < N_CORES; i++) begin
      base   = fresh ? CW'(0) : cur[i];
      acc[i] = $signed(base) + $signed(CW'(weight[i]));
    end
    win_idx  = '0;
    best_val = acc[0];
    for (int i = 1; i < N_CORES; i++) begin
      if (acc[i] > best_val) begin
        win_idx  = IDW'(i);
        best_val = acc[i];
      end
    end
    for (int i = 0; i < N_CORES; i++) begin
      cur_next[i] = (win_idx == IDW'(i)) ? CW'(acc[i] - $signed(CW'(EPOCHS))) : CW'(acc[i]);
    end
  end
endmodule

// File: rtl/sdprio_arbiter.sv
module sdprio_arbiter
  import sdprio_pkg::*;
#(
  parameter int N_CORES   = 4,
  parameter int SD_W      = 8,
  parameter int EPOCHS    = 64,
  parameter int EPOCH_LEN = 16,
  localparam int IDW      = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_CORES*SD_W-1:0]  sd_in,
  output logic [N_CORES-1:0]       prio_vec,
  output logic [IDW-1:0]           prio_id,
  output logic                     interval_tick
);
  localparam int SW = $clog2(EPOCHS + 1);
  localparam int CW = SW + 2;

  logic                        epoch_end, interval_end, calc_idle;
  logic [N_CORES-1:0][SW-1:0]  next_share, active_share, pick_weight;
  logic [N_CORES-1:0][CW-1:0]  credit_q, credit_next;
  logic [IDW-1:0]              win_idx;

  sdprio_epoch_timer #(.EPOCHS(EPOCHS), .EPOCH_LEN(EPOCH_LEN)) timer_i (
    .clk(clk), .rst(rst), .epoch_end(epoch_end), .interval_end(interval_end)
  );

  sdprio_share_calc #(.N_CORES(N_CORES), .SD_W(SD_W), .EPOCHS(EPOCHS)) calc_i (
    .clk(clk), .rst(rst), .start(interval_end), .sd_in(sd_in),
    .next_share(next_share), .idle(calc_idle)
  );

  // a new interval picks with fresh shares and zeroed credits
  assign pick_weight = interval_end ? next_share : active_share;

  sdprio_credit_pick #(.N_CORES(N_CORES), .EPOCHS(EPOCHS)) pick_i (
    .fresh(interval_end), .cur(credit_q), .weight(pick_weight),
    .win_idx(win_idx), .cur_next(credit_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      credit_q      <= '0;
      prio_vec      <= '0;
      prio_id       <= '0;
      interval_tick <= 1'b0;
      for (int i = 0; i < N_CORES; i++)
        active_share[i] <= SW'(equal_share(EPOCHS, N_CORES, i));
    end else begin
      interval_tick <= interval_end;
      if (interval_end) active_share <= next_share;
      if (epoch_end) begin
        credit_q <= credit_next;
        prio_id  <= win_idx;
        for (int i = 0; i < N_CORES; i++) prio_vec[i] <= (win_idx == IDW'(i));
      end
    end
  end
endmodule

// File: rtl/sdprio_checker.sv
module sdprio_checker #(
  parameter int N_CORES   = 4,
  parameter int EPOCHS    = 64,
  localparam int SW       = $clog2(EPOCHS + 1),
  localparam int IDW      = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input logic                        clk,
  input logic                        rst,
  input logic [N_CORES-1:0]          prio_vec,
  input logic [IDW-1:0]              prio_id,
  input logic                        interval_tick,
  input logic                        epoch_end,
  input logic                        interval_end,
  input logic                        calc_idle,
  input logic [N_CORES-1:0][SW-1:0]  active_share
);
  logic live_q;
  int   share_total;
  logic all_nonzero;

  always_ff @(posedge clk) begin
    if (rst) live_q <= 1'b0;
    else     live_q <= 1'b1;
  end

  always_comb begin
    share_total = 0;
    all_nonzero = 1'b1;
    for (int i = 0; i < N_CORES; i++) begin
      share_total = share_total + int'(active_share[i]);
      if (active_share[i] == '0) all_nonzero = 1'b0;
    end
  end

  assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    live_q |-> $onehot(prio_vec));
  assert_id_match_R2: assert property (@(posedge clk) disable iff (rst)
    live_q |-> prio_vec[prio_id]);
  assert_epoch_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (live_q && !$past(epoch_end)) |-> $stable(prio_vec));
  assert_tick_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    interval_tick |=> !interval_tick);
  assert_share_total_R4: assert property (@(posedge clk) disable iff (rst)
    live_q |-> (share_total == EPOCHS && all_nonzero));
  assert_share_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    (live_q && !$past(interval_end)) |-> $stable(active_share));
  assert_calc_ready_R7: assert property (@(posedge clk) disable iff (rst)
    interval_end |-> calc_idle);
endmodule

bind sdprio_arbiter sdprio_checker #(.N_CORES(N_CORES), .EPOCHS(EPOCHS)) chk_i (
  .clk(clk), .rst(rst), .prio_vec(prio_vec), .prio_id(prio_id),
  .interval_tick(interval_tick), .epoch_end(epoch_end),
  .interval_end(interval_end), .calc_idle(calc_idle),
  .active_share(active_share)
);

// File: tb/sdprio_arbiter_tb_top.sv
module sdprio_arbiter_tb_top;
  localparam int N    = 4;
  localparam int SDW  = 8;
  localparam int E    = 64;
  localparam int LEN  = 4;
  localparam int IDW  = 2;
  localparam int NPAT = 6;

  typedef logic [N-1:0][7:0] share_t;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [N*SDW-1:0]    sd_in;
  logic [N-1:0]        prio_vec;
  logic [IDW-1:0]      prio_id;
  logic                interval_tick;

  always #5 clk = ~clk;

  sdprio_arbiter #(.N_CORES(N), .SD_W(SDW), .EPOCHS(E), .EPOCH_LEN(LEN)) dut_i (
    .clk(clk), .rst(rst), .sd_in(sd_in), .prio_vec(prio_vec),
    .prio_id(prio_id), .interval_tick(interval_tick)
  );

  int     n_cmp = 0;
  int     n_bad = 0;
  bit     done  = 0;
  share_t exp_q[$];
  string  tag_q[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // shares from R4, R5, R6
  function automatic share_t model(input logic [N*SDW-1:0] v);
    int s[N];
    int q[N];
    int tot = 0;
    int used = 0;
    int left;
    int rank;
    share_t r;
    for (int i = 0; i < N; i++) begin
      s[i] = int'(v[i*SDW +: SDW]);
      if (s[i] == 0) s[i] = 1;
      tot += s[i];
    end
    for (int i = 0; i < N; i++) begin
      q[i] = ((E - N) * s[i]) / tot;
      used += q[i];
    end
    left = (E - N) - used;
    for (int i = 0; i < N; i++) begin
      rank = 0;
      for (int j = 0; j < N; j++)
        if (j != i && (s[j] > s[i] || (s[j] == s[i] && j < i))) rank++;
      r[i] = 8'(1 + q[i] + ((rank < left) ? 1 : 0));
    end
    return r;
  endfunction

  function automatic logic [N*SDW-1:0] pat(input int k);
    case (k)
      0: return {8'd50, 8'd50, 8'd100, 8'd200};
      1: return {8'd1, 8'd1, 8'd1, 8'd255};
      2: return {8'd7, 8'd5, 8'd5, 8'd5};
      3: return {8'd0, 8'd0, 8'd0, 8'd0};
      4: return {8'd0, 8'd255, 8'd0, 8'd0};
      default: return {8'd40, 8'd40, 8'd40, 8'd40};
    endcase
  endfunction

  function automatic string pat_tag(input int k);
    case (k)
      0, 1: return "R4";
      2: return "R5";
      3, 4: return "R6";
      default: return "R7";
    endcase
  endfunction

  // driver
  initial begin
    share_t eq;
    for (int i = 0; i < N; i++) eq[i] = 8'(E / N);
    sd_in = {8'd100, 8'd100, 8'd100, 8'd100};
    exp_q.push_back(eq);          tag_q.push_back("R1");
    exp_q.push_back(model(sd_in)); tag_q.push_back("R8");
    repeat (5) begin
      @(negedge clk);
      check(prio_vec == '0, "R1", "prio_vec in reset", int'(prio_vec), 0);
      check(interval_tick == 1'b0, "R1", "tick in reset", int'(interval_tick), 0);
    end
    rst = 1'b0;
    for (int k = 0; k < NPAT; k++) begin
      do @(negedge clk); while (!interval_tick);
      // decoy value, replaced well before the boundary (R7)
      sd_in = {8'd3, 8'd200, 8'd9, 8'd1};
      repeat (20) @(negedge clk);
      sd_in = pat(k);
      exp_q.push_back(model(pat(k)));
      tag_q.push_back(pat_tag(k));
    end
  end

  // monitor
  int     cyc_in = 0;
  int     epochs = 0;
  int     ep_cnt[N];
  bit     started = 0;
  bit     eq_mode = 0;
  logic [N-1:0] held;
  share_t e_cur;
  string  t_cur;

  always @(negedge clk) begin
    if (!rst && !done) begin
      if (interval_tick) begin
        if (started) begin
          e_cur = exp_q.pop_front();
          t_cur = tag_q.pop_front();
          for (int i = 0; i < N; i++)
            check(ep_cnt[i] == int'(e_cur[i]), t_cur, $sformatf("epochs of core %0d", i),
                  ep_cnt[i], int'(e_cur[i]));
          check(epochs == E, "R3", "epochs per interval", epochs, E);
          if (exp_q.size() == 0) finish_run();
        end
        started = 1;
        cyc_in  = 0;
        epochs  = 0;
        for (int i = 0; i < N; i++) ep_cnt[i] = 0;
        eq_mode = 1;
        if (exp_q.size() > 0)
          for (int i = 0; i < N; i++) if (int'(exp_q[0][i]) != E / N) eq_mode = 0;
      end
      if (started && !done) begin
        if (cyc_in % LEN == 0) begin
          check(prio_vec == (N'(1) << prio_id), "R2", "one-hot vs id",
                int'(prio_vec), int'(N'(1) << prio_id));
          if (eq_mode)
            check(int'(prio_id) == epochs % N, "R8", "rotation order",
                  int'(prio_id), epochs % N);
          if (epochs < E) ep_cnt[prio_id]++;
          held = prio_vec;
          epochs++;
        end else begin
          check(prio_vec == held, "R3", "hold within epoch", int'(prio_vec), int'(held));
        end
        cyc_in++;
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule